// File: doc/BRIEF.md
# SPI Boot and Wake-Up Sequencer

This block sits on the host side of a serial peripheral link to a wireless device. It takes the device from power-on to a ready state. It issues single register reads and writes through a request/acknowledge command port to an SPI master, which lies outside this block.

After a start pulse the block works through a fixed order. It polls a signature register until the expected pattern comes back, within a bounded window. It then sets the wake-up bit in the bus configuration register. On a first (cold) boot it polls the low-power clock status and writes the crystal frequency into the power-management unit. Last, it waits for the chip-ready interrupt, whose active level is selectable.

Each waiting stage has its own cycle budget. When a budget runs out, the block stops in an error state with a sticky timeout flag and a stage code. Once the device is ready, a wake request from sleep repeats only the wake-up write and the interrupt wait.

Top module: `boot_wake_seq`

## Requirements
- R1: While reset is held and right after it is released, `cmd_req`, `busy`, `done`, `err` and `timed_out` are 0 and `err_code` is 0.
- R2: A start pulse accepted while idle, done or in error leads to repeated reads (`cmd_fn`=0, `cmd_addr`=0x14, `cmd_wr`=0). Polling stops at the first read that returns exactly the signature 0xFEEDBEAD; a read differing in any bit does not count.
- R3: A mismatching signature read whose acknowledge edge comes more than `RST_CYCLES` clock edges after the edge that accepted start ends the boot. The block goes to error with `err_code`=1 and `timed_out`=1. Both stay set until the next accepted start, which clears them.
- R4: After the signature matches, the block writes function 0, address 0x00, with data 0x90 | (`irq_pol` << 5). That is: bit 7 wake, bit 5 interrupt level, bit 4 fast edge mode, all other bits 0.
- R5: On a cold boot (`warm`=0 at start), the wake write is followed by reads of function 1, address 0x1000E, repeated until bit 6 of the returned data is 1. If the `LPCLK_CYCLES` budget is spent, the block errors with `err_code`=2.
- R6: After the clock bit is seen, the block writes the crystal value 26 to function 1, address 0x10030.
- R7: With `warm`=1 at start, no function 1 command is issued. The wake write is followed directly by the interrupt wait.
- R8: In the interrupt wait, `dev_irq` at its active level (high if `irq_pol`=1, low if 0) leads to `done`=1 and `busy`=0. If the interrupt does not arrive within `PLL_CYCLES`, the block errors with `err_code`=3 and `timed_out`=1.
- R9: While `cmd_ack` is low, `cmd_req` and all command fields hold steady. In the cycle after an acknowledge, `cmd_req` is 0.
- R10: A `wake_req` in the done state drops `done` and raises `busy` on the next cycle. It issues exactly one command, the wake write of R4, and returns to done on the ready interrupt.
- R11: A start pulse while `busy` is 1 has no effect: no command is issued and the sequence goes on to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a boot from power-on |
| warm | input | 1 | Sampled at start: 1 skips clock wait and crystal write |
| wake_req | input | 1 | Wake the device from sleep (accepted in done) |
| irq_pol | input | 1 | Active level of the device interrupt, 1 = high |
| dev_irq | input | 1 | Device interrupt line, asynchronous |
| cmd_req | output | 1 | Command request to the SPI master |
| cmd_fn | output | FN_W | Function number of the command |
| cmd_addr | output | ADDR_W | Register address of the command |
| cmd_wr | output | 1 | 1 = write, 0 = read |
| cmd_wdata | output | DATA_W | Write data |
| cmd_ack | input | 1 | Command completed this cycle |
| cmd_rdata | input | DATA_W | Read data, valid with `cmd_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Device reported ready |
| err | output | 1 | Sequence stopped on a timeout |
| err_code | output | 2 | 1 reset window, 2 clock wait, 3 ready interrupt wait |
| timed_out | output | 1 | Sticky timeout flag |

## Verification
The hardest case to reach is the edge of the reset window. Whether a late mismatching poll ends the boot depends on the exact edge at which the master acknowledges it, relative to the start edge. The bench's responder sweeps the number of mismatching replies against several acknowledge latencies. This lands poll completions on, just before and just past the window limit. For each completion the bench predicts the outcome from the edge distance it counts itself. Warm and cold boots and both interrupt levels are folded into the same sweep.

// File: rtl/bws_pkg.sv
`timescale 1ns/1ps
package bws_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_WAKE, S_LPCLK, S_XTAL, S_IRQ, S_DONE, S_ERR
  } bws_state_t;

  typedef enum logic [1:0] {
    E_NONE  = 2'd0,
    E_RESET = 2'd1,
    E_LPCLK = 2'd2,
    E_PLL   = 2'd3
  } bws_err_t;

  localparam int FN_BUS       = 0;
  localparam int FN_BACKPLANE = 1;

  // bus configuration byte: bit7 wake, bit5 interrupt level, bit4 fast edge mode
  function automatic logic [7:0] wake_byte(input logic level_high);
    return {1'b1, 1'b0, level_high, 1'b1, 4'b0000};
  endfunction

  function automatic logic word_match(input logic [63:0] got, input logic [63:0] want);
    return got == want;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bws_timer.sv
`timescale 1ns/1ps
module bws_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (cnt_q < limit)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/bws_irq_sync.sv
`timescale 1ns/1ps
module bws_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_pol,
  input  logic dev_irq,
  output logic irq_seen
);
  logic              active_raw;
  logic [STAGES-1:0] sh_q;

  assign active_raw = ~(dev_irq ^ irq_pol);

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= active_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], active_raw};
      end
    end
  endgenerate

  assign irq_seen = sh_q[STAGES-1];
endmodule

// File: rtl/bws_cmd_port.sv
`timescale 1ns/1ps
module bws_cmd_port #(
  parameter int FN_W   = 2,
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [FN_W-1:0]   i_fn,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic              i_wr,
  input  logic [DATA_W-1:0] i_wdata,
  input  logic              ack,
  output logic              o_req,
  output logic [FN_W-1:0]   o_fn,
  output logic [ADDR_W-1:0] o_addr,
  output logic              o_wr,
  output logic [DATA_W-1:0] o_wdata,
  output logic              complete
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_req   <= 1'b0;
      o_fn    <= '0;
      o_addr  <= '0;
      o_wr    <= 1'b0;
      o_wdata <= '0;
    end else if (o_req) begin
      if (ack) o_req <= 1'b0;
    end else if (issue) begin
      o_req   <= 1'b1;
      o_fn    <= i_fn;
      o_addr  <= i_addr;
      o_wr    <= i_wr;
      o_wdata <= i_wdata;
    end
  end

  assign complete = o_req & ack;
endmodule

// File: rtl/boot_wake_seq.sv
`timescale 1ns/1ps
module boot_wake_seq
  import bws_pkg::*;
#(
  parameter int                FN_W         = 2,
  parameter int                ADDR_W       = 17,
  parameter int                DATA_W       = 32,
  parameter logic [ADDR_W-1:0] SIG_ADDR     = 'h14,
  parameter logic [DATA_W-1:0] SIG_PATTERN  = 'hFEEDBEAD,
  parameter logic [ADDR_W-1:0] CFG_ADDR     = 'h0,
  parameter logic [ADDR_W-1:0] CLK_ADDR     = 'h1000E,
  parameter int                CLK_BIT      = 6,
  parameter logic [ADDR_W-1:0] XTAL_ADDR    = 'h10030,
  parameter logic [DATA_W-1:0] XTAL_VALUE   = 'd26,
  parameter int                RST_CYCLES   = 30_000_000,
  parameter int                LPCLK_CYCLES = 2_000_000,
  parameter int                PLL_CYCLES   = 2_000_000,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              warm,
  input  logic              wake_req,
  input  logic              irq_pol,
  input  logic              dev_irq,
  output logic              cmd_req,
  output logic [FN_W-1:0]   cmd_fn,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_wr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_ack,
  input  logic [DATA_W-1:0] cmd_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              timed_out
);
  localparam int MAX_WAIT = max3(RST_CYCLES, LPCLK_CYCLES, PLL_CYCLES);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  bws_state_t state_q, state_d;
  bws_err_t   code_q, code_d;
  logic       cold_q, cold_d;
  logic       tout_q, tout_d;

  // named internal events, also observed by the checker
  logic              want_cmd, issue, cmd_done;
  logic              in_poll, sig_ok, clk_ok;
  logic              irq_seen, tmr_expired, tmr_clr;
  logic [CNT_W-1:0]  tmr_limit;
  logic [FN_W-1:0]   c_fn;
  logic [ADDR_W-1:0] c_addr;
  logic              c_wr;
  logic [DATA_W-1:0] c_wdata;

  bws_cmd_port #(.FN_W(FN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .i_fn(c_fn), .i_addr(c_addr), .i_wr(c_wr), .i_wdata(c_wdata),
    .ack(cmd_ack),
    .o_req(cmd_req), .o_fn(cmd_fn), .o_addr(cmd_addr), .o_wr(cmd_wr),
    .o_wdata(cmd_wdata), .complete(cmd_done)
  );

  bws_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_limit),
    .expired(tmr_expired)
  );

  bws_irq_sync #(.STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_pol(irq_pol), .dev_irq(dev_irq),
    .irq_seen(irq_seen)
  );

  assign sig_ok  = word_match(64'(cmd_rdata), 64'(SIG_PATTERN));
  assign clk_ok  = cmd_rdata[CLK_BIT];
  assign in_poll = (state_q == S_POLL);

  always_comb begin
    unique case (state_q)
      S_POLL:  tmr_limit = CNT_W'(RST_CYCLES);
      S_LPCLK: tmr_limit = CNT_W'(LPCLK_CYCLES);
      default: tmr_limit = CNT_W'(PLL_CYCLES);
    endcase
  end

  // command fields per stage
  always_comb begin
    want_cmd = 1'b0;
    c_fn     = FN_W'(FN_BUS);
    c_addr   = SIG_ADDR;
    c_wr     = 1'b0;
    c_wdata  = '0;
    unique case (state_q)
      S_POLL: want_cmd = 1'b1;
      S_WAKE: begin
        want_cmd = 1'b1;
        c_addr   = CFG_ADDR;
        c_wr     = 1'b1;
        c_wdata  = DATA_W'(wake_byte(irq_pol));
      end
      S_LPCLK: begin
        want_cmd = 1'b1;
        c_fn     = FN_W'(FN_BACKPLANE);
        c_addr   = CLK_ADDR;
      end
      S_XTAL: begin
        want_cmd = 1'b1;
        c_fn     = FN_W'(FN_BACKPLANE);
        c_addr   = XTAL_ADDR;
        c_wr     = 1'b1;
        c_wdata  = XTAL_VALUE;
      end
      default: want_cmd = 1'b0;
    endcase
  end

  assign issue = want_cmd & ~cmd_req;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    cold_d  = cold_q;
    tout_d  = tout_q;
    unique case (state_q)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          state_d = S_POLL;
          cold_d  = ~warm;
          code_d  = E_NONE;
          tout_d  = 1'b0;
        end else if (state_q == S_DONE && wake_req) begin
          state_d = S_WAKE;
        end
      end
      S_POLL: begin
        if (cmd_done) begin
          if (sig_ok) begin
            state_d = S_WAKE;
          end else if (tmr_expired) begin
            state_d = S_ERR;
            code_d  = E_RESET;
            tout_d  = 1'b1;
          end
        end
      end
      S_WAKE: begin
        if (cmd_done) state_d = cold_q ? S_LPCLK : S_IRQ;
      end
      S_LPCLK: begin
        if (cmd_done) begin
          if (clk_ok) begin
            state_d = S_XTAL;
          end else if (tmr_expired) begin
            state_d = S_ERR;
            code_d  = E_LPCLK;
            tout_d  = 1'b1;
          end
        end
      end
      S_XTAL: begin
        if (cmd_done) state_d = S_IRQ;
      end
      S_IRQ: begin
        if (irq_seen) begin
          state_d = S_DONE;
          cold_d  = 1'b0;
        end else if (tmr_expired) begin
          state_d = S_ERR;
          code_d  = E_PLL;
          tout_d  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      code_q  <= E_NONE;
      cold_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      cold_q  <= cold_d;
      tout_q  <= tout_d;
    end
  end

  assign busy      = (state_q != S_IDLE) && (state_q != S_DONE) && (state_q != S_ERR);
  assign done      = (state_q == S_DONE);
  assign err       = (state_q == S_ERR);
  assign err_code  = code_q;
  assign timed_out = tout_q;
endmodule

// File: rtl/bws_checker.sv
`timescale 1ns/1ps
module bws_checker #(
  parameter int                FN_W     = 2,
  parameter int                ADDR_W   = 17,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SIG_ADDR = 'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wake_req,
  input logic              cmd_req,
  input logic              cmd_ack,
  input logic [FN_W-1:0]   cmd_fn,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_wr,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [1:0]        err_code,
  input logic              timed_out,
  input logic              irq_seen,
  input logic              in_poll,
  input logic              cold_q,
  input logic              tmr_expired
);
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_fn) && $stable(cmd_addr)
                               && $stable(cmd_wr) && $stable(cmd_wdata)));

  a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_ack) |=> !cmd_req);

  a_r2_poll_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (in_poll && cmd_req) |-> (cmd_fn == '0 && cmd_addr == SIG_ADDR && !cmd_wr));

  a_r3_late_poll_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err) && err_code == 2'd1) |-> $past(tmr_expired));

  a_r3_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !start) |=> timed_out);

  a_r7_backplane_cold_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_fn == FN_W'(1)) |-> cold_q);

  a_r8_done_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(irq_seen));

  a_r10_wake_leaves_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wake_req && !start) |=> (busy && !done));
endmodule

bind boot_wake_seq bws_checker #(
  .FN_W(FN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_ADDR(SIG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wake_req(wake_req),
  .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_fn(cmd_fn), .cmd_addr(cmd_addr),
  .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .err(err),
  .err_code(err_code), .timed_out(timed_out), .irq_seen(irq_seen),
  .in_poll(in_poll), .cold_q(cold_q), .tmr_expired(tmr_expired)
);

// File: tb/boot_wake_seq_bench.sv
`timescale 1ns/1ps
module boot_wake_seq_bench;
  localparam int AW = 17, DW = 32, FW = 2;
  localparam int TB_RST = 40, TB_LP = 30, TB_PLL = 30;
  localparam logic [AW-1:0] A_SIG = 17'h14, A_CFG = 17'h0;
  localparam logic [AW-1:0] A_CLK = 17'h1000E, A_XTAL = 17'h10030;
  localparam logic [DW-1:0] PAT = 32'hFEEDBEAD, XVAL = 32'd26;
  localparam int CB = 6;
  localparam int NEVER = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, warm = 1'b0, wake_req = 1'b0, irq_pol = 1'b1;
  logic dev_irq;
  logic cmd_req, cmd_wr, busy, done, err, timed_out;
  logic [FW-1:0] cmd_fn;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [1:0] err_code;
  logic cmd_ack;
  logic [DW-1:0] cmd_rdata;

  always #2.5 clk = ~clk;

  boot_wake_seq #(
    .RST_CYCLES(TB_RST), .LPCLK_CYCLES(TB_LP), .PLL_CYCLES(TB_PLL)
  ) u_boot_wake_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .warm(warm), .wake_req(wake_req),
    .irq_pol(irq_pol), .dev_irq(dev_irq), .cmd_req(cmd_req), .cmd_fn(cmd_fn),
    .cmd_addr(cmd_addr), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .timed_out(timed_out)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int start_cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // responder standing in for the SPI master
  int  cfg_m = 0, cfg_l = 0, cfg_p = 0;
  bit  cfg_irq = 1'b0, cfg_warm = 1'b0;
  bit  irq_on = 1'b0;
  bit  ack_r = 1'b0, pend = 1'b0, pred_to = 1'b0;
  int  lat = 0, poll_n = 0, lp_n = 0, nlog = 0;
  logic [DW-1:0] rd_r = '0;
  logic [FW+AW+DW:0] cap;
  logic [FW-1:0] log_fn   [0:63];
  logic [AW-1:0] log_addr [0:63];
  logic          log_wr   [0:63];
  logic [DW-1:0] log_data [0:63];

  assign cmd_ack   = ack_r;
  assign cmd_rdata = rd_r;
  assign dev_irq   = irq_pol ? irq_on : ~irq_on;

  always @(negedge clk) begin
    if (!rst_n) begin
      ack_r = 1'b0;
      pend  = 1'b0;
    end else if (ack_r) begin
      ack_r = 1'b0;
      chk(!cmd_req, "R9 request low after ack", cmd_req, 0);
    end else if (cmd_req) begin
      if (!pend) begin
        pend = 1'b1;
        lat  = 0;
        cap  = {cmd_fn, cmd_addr, cmd_wr, cmd_wdata};
      end else if (cap != {cmd_fn, cmd_addr, cmd_wr, cmd_wdata}) begin
        chk(1'b0, "R9 fields held", {cmd_fn, cmd_addr, cmd_wr, cmd_wdata}, cap);
      end
      if (lat >= cfg_l) begin
        pend  = 1'b0;
        ack_r = 1'b1;
        rd_r  = '0;
        if (!cmd_wr && cmd_fn == 0 && cmd_addr == A_SIG) begin
          if (poll_n >= cfg_m) rd_r = PAT;
          else begin
            rd_r = PAT ^ (32'h1 << (poll_n % 32));
            if (cyc - start_cyc > TB_RST) pred_to = 1'b1;
          end
          poll_n++;
        end else if (!cmd_wr && cmd_fn == 1 && cmd_addr == A_CLK) begin
          rd_r = (lp_n >= cfg_p) ? (32'h1 << CB) : ~(32'h1 << CB);
          lp_n++;
        end else if (cmd_wr && ((cmd_fn == 0 && cfg_warm) || cmd_fn == 1)) begin
          irq_on = cfg_irq;
        end
        if (nlog < 64) begin
          log_fn[nlog]   = cmd_fn;
          log_addr[nlog] = cmd_addr;
          log_wr[nlog]   = cmd_wr;
          log_data[nlog] = cmd_wdata;
        end
        nlog++;
      end else begin
        lat++;
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wait_end();
    int k;
    k = 0;
    while (!(done || err) && k < 4000) begin
      step(1);
      k++;
    end
  endtask

  task automatic launch(input int m, input int l, input int p, input bit w,
                        input bit pol, input bit irqen);
    step(1);
    cfg_m = m; cfg_l = l; cfg_p = p; cfg_warm = w; cfg_irq = irqen;
    irq_on = 1'b0; warm = w; irq_pol = pol;
    nlog = 0; poll_n = 0; lp_n = 0; pred_to = 1'b0;
    step(1);
    start = 1'b1;
    start_cyc = cyc;
    step(1);
    start = 1'b0;
    chk(!timed_out && !err && busy, "R3 start clears flags", {timed_out, err, busy}, 3'b001);
  endtask

  task automatic check_boot(input int m, input int p, input bit w, input bit pol, input bit irqen);
    int i;
    logic [DW-1:0] wk;
    wk = 32'h90 | (pol ? 32'h20 : 32'h0);
    if (pred_to) begin
      chk(err && err_code == 2'd1 && timed_out, "R3 reset window timeout",
          {err, err_code, timed_out}, 4'b1011);
      chk(nlog == poll_n, "R3 only polls issued", nlog, poll_n);
      return;
    end
    i = 0;
    for (int j = 0; j <= m; j++) begin
      chk(log_fn[i] == 0 && log_addr[i] == A_SIG && !log_wr[i], "R2 poll read",
          {log_fn[i], log_addr[i], log_wr[i]}, {2'd0, A_SIG, 1'b0});
      i++;
    end
    chk(log_fn[i] == 0 && log_addr[i] == A_CFG && log_wr[i] && log_data[i] == wk,
        "R4 wake write", log_data[i], wk);
    i++;
    if (!w) begin
      if (p >= NEVER) begin
        chk(err && err_code == 2'd2 && timed_out, "R5 clock wait timeout",
            {err, err_code, timed_out}, 4'b1101);
        return;
      end
      for (int j = 0; j <= p; j++) begin
        chk(log_fn[i] == 1 && log_addr[i] == A_CLK && !log_wr[i], "R5 clock poll",
            {log_fn[i], log_addr[i]}, {2'd1, A_CLK});
        i++;
      end
      chk(log_fn[i] == 1 && log_addr[i] == A_XTAL && log_wr[i] && log_data[i] == XVAL,
          "R6 crystal write", {log_addr[i], log_data[i]}, {A_XTAL, XVAL});
      i++;
    end
    chk(nlog == i, w ? "R7 warm boot command count" : "R6 cold boot command count", nlog, i);
    if (irqen)
      chk(done && !err && !busy, "R8 ready interrupt", {done, err, busy}, 3'b100);
    else
      chk(err && err_code == 2'd3 && timed_out, "R8 ready timeout",
          {err, err_code, timed_out}, 4'b1111);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(2);
    chk(!cmd_req && !busy && !done && !err && !timed_out && err_code == 0,
        "R1 state in reset", {cmd_req, busy, done, err, timed_out, err_code}, 0);
    step(2);
    rst_n = 1'b1;
    step(1);
    chk(!cmd_req && !busy && !done && !err && !timed_out && err_code == 0,
        "R1 state after reset", {cmd_req, busy, done, err, timed_out, err_code}, 0);

    // R2 R3 R4 R5 R6 R7 R8: sweep mismatch count against ack latency
    for (int m = 0; m <= 22; m++) begin
      for (int l = 0; l <= 3; l++) begin
        launch(m, l, m % 3, (m % 4) == 1, ((m + l) % 2) == 0, 1'b1);
        wait_end();
        check_boot(m, m % 3, (m % 4) == 1, ((m + l) % 2) == 0, 1'b1);
      end
    end

    // R5: clock never available
    launch(1, 0, NEVER, 1'b0, 1'b1, 1'b1);
    wait_end();
    check_boot(1, NEVER, 1'b0, 1'b1, 1'b1);
    step(20);
    chk(timed_out && err, "R3 flag sticky", {timed_out, err}, 2'b11);

    // R8: ready interrupt never arrives, both levels
    launch(2, 1, 0, 1'b0, 1'b0, 1'b0);
    wait_end();
    check_boot(2, 0, 1'b0, 1'b0, 1'b0);
    launch(0, 2, 0, 1'b1, 1'b1, 1'b0);
    wait_end();
    check_boot(0, 0, 1'b1, 1'b1, 1'b0);

    // R10: wake from sleep after a cold boot
    launch(1, 1, 1, 1'b0, 1'b0, 1'b1);
    wait_end();
    check_boot(1, 1, 1'b0, 1'b0, 1'b1);
    irq_on = 1'b0;
    step(5);
    chk(done, "R10 done holds before wake", done, 1);
    nlog = 0; cfg_warm = 1'b1; cfg_irq = 1'b1;
    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    chk(busy && !done, "R10 wake leaves done", {busy, done}, 2'b10);
    wait_end();
    chk(done && nlog == 1, "R10 single command on wake", nlog, 1);
    chk(log_fn[0] == 0 && log_addr[0] == A_CFG && log_wr[0] && log_data[0] == 32'h90,
        "R10 wake write data", log_data[0], 32'h90);

    // R11: start pulse ignored during the ready wait
    launch(0, 0, 0, 1'b0, 1'b1, 1'b0);
    while (nlog < 4) step(1);
    step(3);
    start = 1'b1;
    step(1);
    start = 1'b0;
    step(6);
    chk(nlog == 4 && busy, "R11 start ignored while busy", nlog, 4);
    irq_on = 1'b1;
    wait_end();
    chk(done && nlog == 4, "R11 sequence completes", {done, 8'(nlog)}, {1'b1, 8'd4});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule